// File: doc/BRIEF.md
# Standalone Channel Bit-Error Test Controller

This block runs a continuous bit-error test on the receive channels of a multi-channel deserializer. It is controlled from pins alone, with no boundary-scan access. One channel or all channels can be under test. Channels that are not selected keep their normal lock and data paths, so live traffic on them continues while a neighbour is being measured. Pattern generation and pattern checking sit outside the block. Each channel's checker supplies a word-wide error mask every clock, and this block turns those masks into reports on the channel's own data pins.

A filtered activate pin switches the mode on and off. A channel-select code picks one channel, all channels, or nothing. A report-style pin chooses between two reports. The gross report is the default (pin low). In gross style, any errored word sets a sticky flag that drives every report bit of the channel high. In per-bit style, each report bit shows whether its own data bit was in error in the last word. A channel under test pulls its active-low lock indicator low. All outputs are registered one clock after the inputs that produce them.

Top module: `bist_alone_ctrl`

## Requirements
- R1: The test mode changes state only after the activate pin has been sampled at the new level on FILT_LEN (default 4) consecutive rising clock edges. The filtered state updates at the edge of the last of those samples. A shorter run at the new level leaves the mode unchanged.
- R2: While reset is low, and on the first clock after it: every lock output is 1, every report/data output is 0, the mode is off, and all sticky flags are clear. An activate pin held low keeps the block idle.
- R3: With the mode off, every select code gives idle. With the mode on, code c in 0..NUM_CH-1 tests channel c only, code NUM_CH (6 by default) tests all channels, and any higher code (7 by default) is idle.
- R4: One clock after a channel is under test, its lock output is 0. A channel not under test drives its lock and data outputs with the normal lock and data inputs from one clock earlier.
- R5: In gross style (report pin = 0), a tested channel whose error mask has any bit set drives all WORD_W report bits to 1 from the next clock. They stay 1 for as long as the channel remains under test.
- R6: In per-bit style (report pin = 1), report bit i of a tested channel equals bit i of that channel's error mask from one clock earlier, with no holding. Channel c's mask occupies bits c*WORD_W upward of the error vector.
- R7: A channel's sticky flag clears when the mode turns off, when the channel leaves test because the select changed, or on reset. After re-entry, its gross report reads 0 until a new error arrives.
- R8: Errors seen while in per-bit style also set the sticky flag. A change of report style takes effect one clock later, so switching to gross style shows errors already recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| act_pin | input | 1 | Activate request, filtered over FILT_LEN clocks |
| ch_sel | input | SEL_W | Channel-select code |
| bit_mode | input | 1 | Report style: 0 gross (default), 1 per-bit |
| err_mask | input | NUM_CH*WORD_W | Per-channel error masks from the pattern checkers |
| norm_lock_n | input | NUM_CH | Normal active-low lock indicators |
| norm_data | input | NUM_CH*WORD_W | Normal received data words |
| lock_n_o | output | NUM_CH | Lock outputs, forced low on tested channels |
| data_o | output | NUM_CH*WORD_W | Data outputs, replaced by error reports on tested channels |

## Verification
The bench builds the block with its default parameters: six channels, ten-bit words, a three-bit select and a four-clock filter. With these values, every individual select code, the all-channels code and the single idle code can be reached from a three-bit input. Filter runs of three and four samples are cheap to drive, so the boundary where the mode just fails to turn on and the boundary where it just turns on are both exercised. Ten-bit masks give enough bit positions to show per-bit reports with scattered patterns, next to gross reports that fill the whole word.

// File: rtl/bist_alone_pkg.sv
package bist_alone_pkg;

   typedef enum logic {
      RPT_GROSS = 1'b0,
      RPT_BIT   = 1'b1
   } rpt_style_e;

   function automatic int unsigned min_sel_width(input int unsigned n_ch);
      return $clog2(n_ch + 2);
   endfunction

endpackage

// File: rtl/bist_act_filter.sv
module bist_act_filter #(
   parameter int unsigned FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic act_o
);

   generate
      if (FILT_LEN < 1) begin : g_bad_len
         $error("bist_act_filter: FILT_LEN must be at least 1");
      end

      if (FILT_LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) act_o <= 1'b0;
            else        act_o <= pin_i;
         end
      end else begin : g_counted
         localparam int unsigned CNT_W = $clog2(FILT_LEN);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

         logic [CNT_W-1:0] run_q;
         logic             act_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               act_q <= 1'b0;
            end else if (pin_i == act_q) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               run_q <= '0;
               act_q <= pin_i;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign act_o = act_q;
      end
   endgenerate

endmodule

// File: rtl/bist_chan_decode.sv
module bist_chan_decode #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned SEL_W  = 3
) (
   input  logic              act_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [NUM_CH-1:0] tested_o
);

   localparam logic [SEL_W-1:0] ALL_CODE = SEL_W'(NUM_CH);

   logic sel_all;
   assign sel_all = (sel_i == ALL_CODE);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam logic [SEL_W-1:0] MY_CODE = SEL_W'(c);
         assign tested_o[c] = act_i & (sel_all | (sel_i == MY_CODE));
      end
   endgenerate

endmodule

// File: rtl/bist_chan_report.sv
module bist_chan_report
   import bist_alone_pkg::*;
#(
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tested_i,
   input  rpt_style_e        style_i,
   input  logic [WORD_W-1:0] err_i,
   input  logic              norm_lock_n_i,
   input  logic [WORD_W-1:0] norm_data_i,
   output logic              lock_n_o,
   output logic [WORD_W-1:0] data_o
);

   logic              sticky_q;
   logic              sticky_nxt;
   logic [WORD_W-1:0] report;

   assign sticky_nxt = tested_i & (sticky_q | (|err_i));

   always_comb begin
      unique case (style_i)
         RPT_BIT:   report = err_i;
         default:   report = {WORD_W{sticky_nxt}};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
         lock_n_o <= 1'b1;
         data_o   <= '0;
      end else begin
         sticky_q <= sticky_nxt;
         lock_n_o <= tested_i ? 1'b0   : norm_lock_n_i;
         data_o   <= tested_i ? report : norm_data_i;
      end
   end

endmodule

// File: rtl/bist_alone_ctrl.sv
module bist_alone_ctrl
   import bist_alone_pkg::*;
#(
   parameter int unsigned NUM_CH   = 6,
   parameter int unsigned WORD_W   = 10,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned FILT_LEN = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     act_pin,
   input  logic [SEL_W-1:0]         ch_sel,
   input  logic                     bit_mode,
   input  logic [NUM_CH*WORD_W-1:0] err_mask,
   input  logic [NUM_CH-1:0]        norm_lock_n,
   input  logic [NUM_CH*WORD_W-1:0] norm_data,
   output logic [NUM_CH-1:0]        lock_n_o,
   output logic [NUM_CH*WORD_W-1:0] data_o
);

   localparam int unsigned MIN_SEL_W = min_sel_width(NUM_CH);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("bist_alone_ctrl: NUM_CH must be at least 1");
      end
      if (WORD_W < 1) begin : g_bad_w
         $error("bist_alone_ctrl: WORD_W must be at least 1");
      end
      if (SEL_W < MIN_SEL_W) begin : g_bad_sel
         $error("bist_alone_ctrl: SEL_W too narrow for channel, all and idle codes");
      end
   endgenerate

   logic              act_w;
   logic [NUM_CH-1:0] tested_w;
   rpt_style_e        style_w;

   assign style_w = bit_mode ? RPT_BIT : RPT_GROSS;

   bist_act_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (act_pin),
      .act_o (act_w)
   );

   bist_chan_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
      .act_i    (act_w),
      .sel_i    (ch_sel),
      .tested_o (tested_w)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_rpt
         bist_chan_report #(.WORD_W(WORD_W)) u_rpt (
            .clk           (clk),
            .rst_n         (rst_n),
            .tested_i      (tested_w[c]),
            .style_i       (style_w),
            .err_i         (err_mask[c*WORD_W +: WORD_W]),
            .norm_lock_n_i (norm_lock_n[c]),
            .norm_data_i   (norm_data[c*WORD_W +: WORD_W]),
            .lock_n_o      (lock_n_o[c]),
            .data_o        (data_o[c*WORD_W +: WORD_W])
         );
      end
   endgenerate

endmodule

// File: rtl/bist_alone_ctrl_chk.sv
module bist_alone_ctrl_chk #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned WORD_W = 10,
   parameter int unsigned SEL_W  = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     act_pin,
   input logic [SEL_W-1:0]         ch_sel,
   input logic                     bit_mode,
   input logic [NUM_CH*WORD_W-1:0] err_mask,
   input logic [NUM_CH-1:0]        norm_lock_n,
   input logic [NUM_CH-1:0]        lock_n_o,
   input logic [NUM_CH*WORD_W-1:0] data_o,
   input logic                     act_state,
   input logic [NUM_CH-1:0]        tested
);

   localparam logic [SEL_W-1:0] ALL_CODE = SEL_W'(NUM_CH);

   a_r1_filter_level: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_state) |-> (act_state == $past(act_pin)));

   a_r4_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !act_state |=> (lock_n_o == $past(norm_lock_n)));

   a_r3_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_sel > ALL_CODE) |=> (lock_n_o == $past(norm_lock_n)));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         a_r4_lock_low: assert property (@(posedge clk) disable iff (!rst_n)
            tested[c] |=> !lock_n_o[c]);

         a_r6_bit_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (tested[c] && bit_mode) |=>
               (data_o[c*WORD_W +: WORD_W] == $past(err_mask[c*WORD_W +: WORD_W])));

         a_r5_gross_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (tested[c] && !bit_mode && $past(tested[c]) && (&data_o[c*WORD_W +: WORD_W]))
               |=> (&data_o[c*WORD_W +: WORD_W]));
      end
   endgenerate

endmodule

bind bist_alone_ctrl bist_alone_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .WORD_W (WORD_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .act_pin     (act_pin),
   .ch_sel      (ch_sel),
   .bit_mode    (bit_mode),
   .err_mask    (err_mask),
   .norm_lock_n (norm_lock_n),
   .lock_n_o    (lock_n_o),
   .data_o      (data_o),
   .act_state   (act_w),
   .tested      (tested_w)
);

// File: tb/bist_alone_ctrl_tb_top.sv
module bist_alone_ctrl_tb_top;

   localparam int NCH  = 6;
   localparam int W    = 10;
   localparam int SW   = 3;
   localparam int FL   = 4;
   localparam int DW   = NCH * W;
   localparam int NVEC = 16;
   localparam logic [2:0] NOCH = 3'd7;

   typedef struct packed {
      logic       act;
      logic [2:0] sel;
      logic       bm;
      logic [2:0] ech;
      logic [9:0] epat;
      logic [3:0] reps;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 3'd0, 1'b0, NOCH, 10'h000, 4'd3},
      '{1'b1, 3'd2, 1'b0, 3'd2, 10'h0ff, 4'd2},
      '{1'b0, 3'd2, 1'b0, NOCH, 10'h000, 4'd2},
      '{1'b1, 3'd2, 1'b0, NOCH, 10'h000, 4'd6},
      '{1'b1, 3'd2, 1'b0, 3'd2, 10'h004, 4'd1},
      '{1'b1, 3'd2, 1'b0, NOCH, 10'h000, 4'd3},
      '{1'b1, 3'd2, 1'b1, 3'd2, 10'h201, 4'd2},
      '{1'b1, 3'd2, 1'b1, NOCH, 10'h000, 4'd2},
      '{1'b1, 3'd6, 1'b0, 3'd4, 10'h010, 4'd2},
      '{1'b1, 3'd7, 1'b0, 3'd5, 10'h3ff, 4'd2},
      '{1'b1, 3'd0, 1'b1, 3'd0, 10'h3ff, 4'd2},
      '{1'b1, 3'd1, 1'b1, 3'd0, 10'h155, 4'd2},
      '{1'b0, 3'd1, 1'b0, NOCH, 10'h000, 4'd2},
      '{1'b1, 3'd1, 1'b0, 3'd1, 10'h020, 4'd2},
      '{1'b0, 3'd1, 1'b0, NOCH, 10'h000, 4'd6},
      '{1'b0, 3'd3, 1'b0, 3'd3, 10'h0aa, 4'd3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act_pin = 1'b0;
   logic [SW-1:0] ch_sel = '0;
   logic          bit_mode = 1'b0;
   logic [DW-1:0] err_mask = '0;
   logic [NCH-1:0] norm_lock_n = '1;
   logic [DW-1:0] norm_data = '0;
   logic [NCH-1:0] lock_n_o;
   logic [DW-1:0] data_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // independent model state
   logic          m_act = 1'b0;
   int            m_run = 0;
   logic [NCH-1:0] m_st = '0;
   logic [NCH-1:0] e_lock;
   logic [DW-1:0] e_data;

   always #2.5 clk = ~clk;

   bist_alone_ctrl #(.NUM_CH(NCH), .WORD_W(W), .SEL_W(SW), .FILT_LEN(FL)) dut_i (
      .clk(clk), .rst_n(rst_n), .act_pin(act_pin), .ch_sel(ch_sel),
      .bit_mode(bit_mode), .err_mask(err_mask), .norm_lock_n(norm_lock_n),
      .norm_data(norm_data), .lock_n_o(lock_n_o), .data_o(data_o)
   );

   task automatic check(input string tag, input logic [NCH-1:0] xl, input logic [DW-1:0] xd);
      n_chk++;
      if (lock_n_o !== xl || data_o !== xd) begin
         n_bad++;
         $display("FAIL %s lock_n=%h data=%h expected lock_n=%h data=%h",
                  tag, lock_n_o, data_o, xl, xd);
      end
   endtask

   task automatic model_reset();
      m_act = 1'b0;
      m_run = 0;
      m_st  = '0;
   endtask

   // one clock: drive at negedge, predict, check at the next negedge
   task automatic step(input logic a, input logic [2:0] s, input logic bm,
                       input logic [2:0] ech, input logic [9:0] epat, input string tag);
      logic [NCH-1:0] tst;
      logic [NCH-1:0] nst;
      cyc++;
      act_pin     = a;
      ch_sel      = s;
      bit_mode    = bm;
      err_mask    = '0;
      if (ech < NCH) err_mask[ech*W +: W] = epat;
      norm_lock_n = NCH'(cyc) ^ 6'h2a;
      norm_data   = {NCH{W'(cyc * 37)}};
      for (int c = 0; c < NCH; c++) begin
         tst[c] = m_act && ((int'(s) == c) || (int'(s) == NCH));
         nst[c] = tst[c] && (m_st[c] || (|err_mask[c*W +: W]));
         e_lock[c] = tst[c] ? 1'b0 : norm_lock_n[c];
         if (!tst[c])  e_data[c*W +: W] = norm_data[c*W +: W];
         else if (bm)  e_data[c*W +: W] = err_mask[c*W +: W];
         else          e_data[c*W +: W] = {W{nst[c]}};
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, e_lock, e_data);
      m_st = nst;
      if (a == m_act) m_run = 0;
      else if (m_run == FL - 1) begin m_act = a; m_run = 0; end
      else m_run++;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      // R2: reset state
      @(negedge clk);
      @(negedge clk);
      check("R2", '1, '0);
      rst_n = 1'b1;
      model_reset();

      for (int v = 0; v < NVEC; v++) begin
         for (int r = 0; r < int'(VEC[v].reps); r++) begin
            step(VEC[v].act, VEC[v].sel, VEC[v].bm, VEC[v].ech, VEC[v].epat,
                 !m_act ? "R3" : (VEC[v].bm ? "R6" : "R5"));
         end
      end

      // R1: three high samples then a low one do nothing, four turn it on
      for (int i = 0; i < 3; i++) step(1'b1, 3'd0, 1'b0, NOCH, 10'h0, "R1");
      step(1'b0, 3'd0, 1'b0, NOCH, 10'h0, "R1");
      for (int i = 0; i < 4; i++) step(1'b1, 3'd0, 1'b0, NOCH, 10'h0, "R1");
      // R4: now active, channel 0 lock low, others pass normal values
      step(1'b1, 3'd0, 1'b0, NOCH, 10'h0, "R4");
      if (lock_n_o[0] !== 1'b0) begin
         n_bad++;
         $display("FAIL R4 lock_n[0]=%b expected 0", lock_n_o[0]);
      end
      n_chk++;

      // R7: error sets sticky, leave test one clock, return: clean report
      step(1'b1, 3'd0, 1'b0, 3'd0, 10'h080, "R5");
      step(1'b1, 3'd0, 1'b0, NOCH, 10'h0, "R5");
      step(1'b1, 3'd3, 1'b0, NOCH, 10'h0, "R7");
      step(1'b1, 3'd0, 1'b0, NOCH, 10'h0, "R7");
      if (data_o[W-1:0] !== '0) begin
         n_bad++;
         $display("FAIL R7 ch0 report=%h expected 0", data_o[W-1:0]);
      end
      n_chk++;

      // R8: error recorded in per-bit style appears once gross style resumes
      step(1'b1, 3'd0, 1'b1, 3'd0, 10'h002, "R8");
      step(1'b1, 3'd0, 1'b1, NOCH, 10'h0, "R8");
      step(1'b1, 3'd0, 1'b0, NOCH, 10'h0, "R8");
      if (data_o[W-1:0] !== '1) begin
         n_bad++;
         $display("FAIL R8 ch0 report=%h expected %h", data_o[W-1:0], {W{1'b1}});
      end
      n_chk++;

      // R2: reset while active returns everything to idle
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R2", '1, '0);
      rst_n = 1'b1;
      model_reset();
      step(1'b1, 3'd6, 1'b0, 3'd1, 10'h3ff, "R2");
      step(1'b1, 3'd6, 1'b0, NOCH, 10'h0, "R2");

      summary();
      $finish;
   end

endmodule